// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel coordinate outputs for a raster display. It runs on the pixel clock. Software sets it up through a simple write port. Horizontal and vertical timing are each packed into one register word holding the front porch, the sync width and the back porch. A separate extent word holds the visible line count and the visible pixel count per line.

A display-mode register selects one of three behaviours. It can turn the output off. It can pass incoming pixels through. It can replace the picture with a test pattern of eight vertical colour stripes. A background colour fills everything outside the visible area, and it also fills visible pixels whose source is not valid. The sync polarity of each axis can be set on its own. Timing, mode and polarity writes land in shadow copies, which are loaded at a frame boundary, so a running picture never shows a torn frame.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, the block is off. de, hsync, vsync, x_pos, y_pos and rgb are all 0.
- R2: After reset, the timing registers hold a 1280x1024 mode. The horizontal settings are front porch 128, sync 216 and back porch 38. The vertical settings are front porch 7, sync 37 and back porch 2. The background colour is 0x7F7F7F.
- R3: Register addresses on wr_addr are as follows:
  - 0: display mode, in bits [2:0].
  - 1: horizontal word.
  - 2: vertical word.
  - 3: extent word. Bits [31:16] hold the visible lines and bits [15:0] hold the visible pixels per line.
  - 4: background colour, in bits [23:0].
  - 5: sync polarity.
  - 8 to 15: stripe colours 0 to 7.
  Both axis words use the same layout: back porch in [31:22], sync width in [21:11] and front porch in [10:0].
- R4: Each line runs in this order: visible pixels, front porch, sync, back porch. A frame follows the same order, counted in lines. x_pos and y_pos report the position, and y_pos advances after the last pixel of a line.
- R5: de is 1 only when both x_pos and y_pos lie in the visible area. Whenever de is 0 in a running mode, rgb equals the background colour.
- R6: Mode value 4 shows eight stripes. A visible pixel at x takes the colour of stripe floor(x*8/visible_pixels).
- R7: In the polarity register, bit 0 controls hsync and bit 1 controls vsync. A bit of 0 makes that sync active high. A bit of 1 inverts it, and this includes its idle level.
- R8: Timing, mode and polarity writes take effect at the next frame start. The background and stripe colours take effect immediately. When the block is started from off, position (0,0) reaches the outputs on the second rising edge after the edge that writes the mode.
- R9: Once mode 0 has taken effect, x_pos = y_pos = 0, de = 0, rgb = 0, and each sync sits at its inactive level.
- R10: Mode values 1, 2, 3, 5, 6 and 7 mean normal display. A visible pixel shows pix_rgb when pix_valid is 1 and the background colour otherwise. Pixel inputs present in a cycle appear with that cycle's position on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Incoming pixel is valid |
| pix_rgb | input | 24 | Incoming pixel colour |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, visible area |
| x_pos | output | 16 | Current pixel column |
| y_pos | output | 16 | Current line |
| rgb | output | 24 | Output colour |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of a running frame and must wait for the boundary. The bench starts a small frame and rewrites the horizontal word about forty pixels in. It then expects the rest of that frame with the old line length and the next frame with the new one. A mode-0 write placed inside that second frame must leave it intact, and the off state must follow straight after the last pixel. A full 1280x1024 frame would take too long, so the reset-default timing is checked over its first complete line.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef struct packed {
    logic [9:0]  back;
    logic [10:0] sync;
    logic [10:0] front;
  } porch_t;

  typedef struct packed {
    logic [15:0] lines;
    logic [15:0] pixels;
  } extent_t;

  typedef enum logic [1:0] {SHOW_OFF, SHOW_LIVE, SHOW_BARS} show_t;

  localparam int A_MODE = 0;
  localparam int A_HORZ = 1;
  localparam int A_VERT = 2;
  localparam int A_EXT  = 3;
  localparam int A_BG   = 4;
  localparam int A_POL  = 5;

  localparam porch_t  DEF_HORZ = '{back: 10'd38, sync: 11'd216, front: 11'd128};
  localparam porch_t  DEF_VERT = '{back: 10'd2,  sync: 11'd37,  front: 11'd7};
  localparam extent_t DEF_EXT  = '{lines: 16'd1024, pixels: 16'd1280};
  localparam logic [23:0] DEF_BG = 24'h7F7F7F;

  function automatic show_t decode_mode(input logic [2:0] m);
    case (m)
      3'd0:    return SHOW_OFF;
      3'd4:    return SHOW_BARS;
      default: return SHOW_LIVE;
    endcase
  endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RGB_W  = 24,
  parameter int NBARS  = 8,
  localparam int BAR_AW = $clog2(NBARS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic                   frame_end,
  output porch_t                 act_h,
  output porch_t                 act_v,
  output extent_t                act_ext,
  output show_t                  act_show,
  output logic [1:0]             act_pol,
  output logic [RGB_W-1:0]       bg_rgb,
  output logic [NBARS*RGB_W-1:0] bar_rgb
);

  logic [2:0]       mode_q, mode_d;
  porch_t           horz_q, horz_d, vert_q, vert_d;
  extent_t          ext_q, ext_d;
  logic [1:0]       pol_q, pol_d;
  logic [RGB_W-1:0] bg_q, bg_d;
  logic             load;

  always_comb begin
    mode_d = mode_q;
    horz_d = horz_q;
    vert_d = vert_q;
    ext_d  = ext_q;
    pol_d  = pol_q;
    bg_d   = bg_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_MODE): mode_d = wr_data[2:0];
        ADDR_W'(A_HORZ): horz_d = wr_data;
        ADDR_W'(A_VERT): vert_d = wr_data;
        ADDR_W'(A_EXT):  ext_d  = wr_data;
        ADDR_W'(A_BG):   bg_d   = wr_data[RGB_W-1:0];
        ADDR_W'(A_POL):  pol_d  = wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      horz_q <= DEF_HORZ;
      vert_q <= DEF_VERT;
      ext_q  <= DEF_EXT;
      pol_q  <= 2'b00;
      bg_q   <= DEF_BG;
    end else if (wr_en) begin
      mode_q <= mode_d;
      horz_q <= horz_d;
      vert_q <= vert_d;
      ext_q  <= ext_d;
      pol_q  <= pol_d;
      bg_q   <= bg_d;
    end
  end

  for (genvar i = 0; i < NBARS; i++) begin : g_bar
    logic             we;
    logic [RGB_W-1:0] col_q;
    assign we = wr_en && (wr_addr[ADDR_W-1:BAR_AW] == (ADDR_W-BAR_AW)'(1))
                      && (wr_addr[BAR_AW-1:0] == BAR_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  col_q <= '0;
      else if (we) col_q <= wr_data[RGB_W-1:0];
    end
    assign bar_rgb[i*RGB_W +: RGB_W] = col_q;
  end

  // Shadow copies reload every cycle while off, else only at frame end.
  assign load = frame_end || (act_show == SHOW_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_h    <= DEF_HORZ;
      act_v    <= DEF_VERT;
      act_ext  <= DEF_EXT;
      act_show <= SHOW_OFF;
      act_pol  <= 2'b00;
    end else if (load) begin
      act_h    <= horz_q;
      act_v    <= vert_q;
      act_ext  <= ext_q;
      act_show <= decode_mode(mode_q);
      act_pol  <= pol_q;
    end
  end

  assign bg_rgb = bg_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_h) && $stable(act_v) && $stable(act_ext) && $stable(act_pol))); // R8

endmodule

// File: rtl/dtg_axis_cnt.sv
module dtg_axis_cnt #(
  parameter int CNT_W = 16,
  localparam int TOT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] len_act,
  input  logic [10:0]      len_front,
  input  logic [10:0]      len_sync,
  input  logic [9:0]       len_back,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             in_act,
  output logic             in_sync
);

  logic [TOT_W-1:0] sync_lo, sync_hi, total;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign sync_lo = TOT_W'(len_act) + TOT_W'(len_front);
  assign sync_hi = sync_lo + TOT_W'(len_sync);
  assign total   = sync_hi + TOT_W'(len_back);

  assign wrap    = step && (TOT_W'(cnt) == total - TOT_W'(1));
  assign in_act  = cnt < len_act;
  assign in_sync = (TOT_W'(cnt) >= sync_lo) && (TOT_W'(cnt) < sync_hi);

  assign cnt_en = clr || step;

  always_comb begin
    if (clr || wrap) cnt_d = '0;
    else             cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |-> (TOT_W'(cnt) < total)); // R4
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R4

endmodule

// File: rtl/dtg_pix_mux.sv
module dtg_pix_mux
  import dtg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RGB_W = 24,
  parameter int NBARS = 8,
  localparam int IDX_W = $clog2(NBARS),
  localparam int XW    = CNT_W + IDX_W + 1
) (
  input  show_t                  show,
  input  logic                   de,
  input  logic                   pix_valid,
  input  logic [RGB_W-1:0]       pix_rgb,
  input  logic [RGB_W-1:0]       bg_rgb,
  input  logic [NBARS*RGB_W-1:0] bar_rgb,
  input  logic [CNT_W-1:0]       x,
  input  logic [CNT_W-1:0]       width,
  output logic [RGB_W-1:0]       rgb
);

  logic [NBARS-1:1] ge;
  logic [IDX_W-1:0] idx;

  // Stripe k starts where x*NBARS reaches k*width; no divider needed.
  for (genvar k = 1; k < NBARS; k++) begin : g_edge
    assign ge[k] = (XW'(x) * XW'(NBARS)) >= (XW'(width) * XW'(k));
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NBARS; k++) begin
      if (ge[k]) idx = idx + IDX_W'(1);
    end
  end

  always_comb begin
    if (!de)                    rgb = bg_rgb;
    else if (show == SHOW_BARS) rgb = bar_rgb[int'(idx)*RGB_W +: RGB_W];
    else if (pix_valid)         rgb = pix_rgb;
    else                        rgb = bg_rgb;
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int RGB_W  = 24,
  parameter int NBARS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              pix_valid,
  input  logic [RGB_W-1:0]  pix_rgb,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  x_pos,
  output logic [CNT_W-1:0]  y_pos,
  output logic [RGB_W-1:0]  rgb
);

  porch_t                 sh_h, sh_v;
  extent_t                sh_ext;
  show_t                  show;
  logic [1:0]             sh_pol;
  logic [RGB_W-1:0]       bg_rgb, px_rgb;
  logic [NBARS*RGB_W-1:0] bar_rgb;
  logic [CNT_W-1:0]       hc, vc;
  logic                   running, frame_end;
  logic                   h_wrap, v_wrap, h_act, v_act, h_sync, v_sync;
  logic                   de_d, hs_d, vs_d;
  logic [CNT_W-1:0]       x_d, y_d;
  logic [RGB_W-1:0]       rgb_d;

  assign running   = (show != SHOW_OFF);
  assign frame_end = h_wrap && v_wrap;

  dtg_regs #(.ADDR_W(ADDR_W), .RGB_W(RGB_W), .NBARS(NBARS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_end(frame_end), .act_h(sh_h), .act_v(sh_v), .act_ext(sh_ext),
    .act_show(show), .act_pol(sh_pol), .bg_rgb(bg_rgb), .bar_rgb(bar_rgb)
  );

  dtg_axis_cnt #(.CNT_W(CNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(!running), .step(running),
    .len_act(sh_ext.pixels[CNT_W-1:0]), .len_front(sh_h.front),
    .len_sync(sh_h.sync), .len_back(sh_h.back),
    .cnt(hc), .wrap(h_wrap), .in_act(h_act), .in_sync(h_sync)
  );

  dtg_axis_cnt #(.CNT_W(CNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(!running), .step(h_wrap),
    .len_act(sh_ext.lines[CNT_W-1:0]), .len_front(sh_v.front),
    .len_sync(sh_v.sync), .len_back(sh_v.back),
    .cnt(vc), .wrap(v_wrap), .in_act(v_act), .in_sync(v_sync)
  );

  dtg_pix_mux #(.CNT_W(CNT_W), .RGB_W(RGB_W), .NBARS(NBARS)) u_mux (
    .show(show), .de(de_d), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .bg_rgb(bg_rgb), .bar_rgb(bar_rgb), .x(hc),
    .width(sh_ext.pixels[CNT_W-1:0]), .rgb(px_rgb)
  );

  always_comb begin
    de_d  = running && h_act && v_act;
    hs_d  = running ? (h_sync ^ sh_pol[0]) : sh_pol[0];
    vs_d  = running ? (v_sync ^ sh_pol[1]) : sh_pol[1];
    x_d   = running ? hc : '0;
    y_d   = running ? vc : '0;
    rgb_d = running ? px_rgb : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de    <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
      x_pos <= '0;
      y_pos <= '0;
      rgb   <= '0;
    end else begin
      de    <= de_d;
      hsync <= hs_d;
      vsync <= vs_d;
      x_pos <= x_d;
      y_pos <= y_d;
      rgb   <= rgb_d;
    end
  end

  AST_DE_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((x_pos < sh_ext.pixels[CNT_W-1:0]) && (y_pos < sh_ext.lines[CNT_W-1:0]))); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (show == SHOW_OFF) |=> (!de && rgb == '0 && x_pos == '0 && y_pos == '0)); // R9
  AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (show == SHOW_OFF) |=> (hsync == $past(sh_pol[0]) && vsync == $past(sh_pol[1]))); // R7
  AST_BAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (de && x_pos == '0 && $past(show) == SHOW_BARS) |-> (rgb == $past(bar_rgb[RGB_W-1:0]))); // R6

endmodule

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;

  typedef struct {
    logic        hs, vs, de;
    logic [15:0] x, y;
    logic [23:0] rgb;
    string       tag;
  } item_t;

  typedef struct {
    int          W, H, hf, hs, hb, vf, vs, vb, mode;
    logic [1:0]  pol;
    logic [23:0] bg;
    logic [23:0] bar [8];
    logic        pv;
    logic [23:0] pix;
  } cfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_rgb = '0;
  logic        hsync, vsync, de;
  logic [15:0] x_pos, y_pos;
  logic [23:0] rgb;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    mon_en = 0;
  item_t q[$];
  item_t mon_it;

  always #5 clk = ~clk;

  disp_timing_gen u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb), .hsync(hsync), .vsync(vsync),
    .de(de), .x_pos(x_pos), .y_pos(y_pos), .rgb(rgb)
  );

  function automatic item_t exp_at(int h, int v, cfg_t c, string tag);
    item_t it;
    bit hin, vin;
    it.x   = 16'(h);
    it.y   = 16'(v);
    it.de  = (h < c.W) && (v < c.H);
    hin    = (h >= c.W + c.hf) && (h < c.W + c.hf + c.hs);
    vin    = (v >= c.H + c.vf) && (v < c.H + c.vf + c.vs);
    it.hs  = hin ^ c.pol[0];
    it.vs  = vin ^ c.pol[1];
    if (!it.de)          it.rgb = c.bg;
    else if (c.mode == 4) it.rgb = c.bar[(h * 8) / c.W];
    else                  it.rgb = c.pv ? c.pix : c.bg;
    it.tag = tag;
    return it;
  endfunction

  function automatic item_t off_item(logic [1:0] pol, string tag);
    item_t it;
    it.hs = pol[0]; it.vs = pol[1]; it.de = 1'b0;
    it.x = '0; it.y = '0; it.rgb = '0; it.tag = tag;
    return it;
  endfunction

  task automatic push_rows(cfg_t c, int rows, string tag);
    for (int v = 0; v < rows; v++)
      for (int h = 0; h < c.W + c.hf + c.hs + c.hb; h++)
        q.push_back(exp_at(h, v, c, tag));
  endtask

  task automatic push_frame(cfg_t c, string tag);
    push_rows(c, c.H + c.vf + c.vs + c.vb, tag);
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_cfg(cfg_t c);
    write_reg(1, {10'(c.hb), 11'(c.hs), 11'(c.hf)});
    write_reg(2, {10'(c.vb), 11'(c.vs), 11'(c.vf)});
    write_reg(3, {16'(c.H), 16'(c.W)});
    write_reg(4, {8'h0, c.bg});
    write_reg(5, {30'h0, c.pol});
    for (int i = 0; i < 8; i++) write_reg(8 + i, {8'h0, c.bar[i]});
    pix_valid = c.pv;
    pix_rgb   = c.pix;
  endtask

  // Write the mode and arm the monitor on the edge that shows position (0,0) (R8).
  task automatic start(cfg_t c);
    write_reg(0, 32'(c.mode));
    @(posedge clk);
    @(posedge clk);
    mon_en = 1;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    mon_en = 0;
  endtask

  task automatic settle();
    write_reg(0, 32'd0);
    repeat (500) @(posedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      mon_it = q.pop_front();
      n_chk++;
      if (hsync !== mon_it.hs || vsync !== mon_it.vs || de !== mon_it.de ||
          x_pos !== mon_it.x || y_pos !== mon_it.y || rgb !== mon_it.rgb) begin
        n_bad++;
        $display("FAIL %s: actual hs=%b vs=%b de=%b x=%0d y=%0d rgb=%h expected hs=%b vs=%b de=%b x=%0d y=%0d rgb=%h",
                 mon_it.tag, hsync, vsync, de, x_pos, y_pos, rgb,
                 mon_it.hs, mon_it.vs, mon_it.de, mon_it.x, mon_it.y, mon_it.rgb);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_t d, s, s2;

    repeat (3) @(negedge clk);
    chk("R1 de in reset", 64'(de), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 hsync", 64'(hsync), 64'd0);
    chk("R1 vsync", 64'(vsync), 64'd0);
    chk("R1 de", 64'(de), 64'd0);
    chk("R1 xy", {32'(x_pos), 32'(y_pos)}, 64'd0);
    chk("R1 rgb", 64'(rgb), 64'd0);

    // R2: reset-default 1280x1024 timing, first full line
    d.W = 1280; d.H = 1024; d.hf = 128; d.hs = 216; d.hb = 38;
    d.vf = 7; d.vs = 37; d.vb = 2; d.mode = 1; d.pol = 2'b00; d.bg = 24'h7F7F7F;
    for (int i = 0; i < 8; i++) d.bar[i] = '0;
    d.pv = 1'b1; d.pix = 24'h00C0DE;
    pix_valid = 1'b1; pix_rgb = d.pix;
    push_rows(d, 1, "R2 R4 R5 default line");
    start(d);
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R10: small programmed frame, mode 1, two frames back to back
    s.W = 16; s.H = 4; s.hf = 2; s.hs = 3; s.hb = 1;
    s.vf = 1; s.vs = 2; s.vb = 1; s.mode = 1; s.pol = 2'b00; s.bg = 24'h001020;
    for (int i = 0; i < 8; i++) s.bar[i] = {8'(i * 30), 8'(255 - i), 8'h55};
    s.pv = 1'b1; s.pix = 24'h123456;
    program_cfg(s);
    push_frame(s, "R3 R4 R5 R10 frame A");
    push_frame(s, "R4 R10 frame B wrap");
    start(s);
    drain();
    settle();

    // R10: mode 2 is normal display; invalid pixels show background
    s.mode = 2; s.pv = 1'b0; s.bg = 24'h0A0B0C;
    program_cfg(s);
    push_frame(s, "R10 R5 mode2 invalid");
    start(s);
    drain();
    settle();

    // R6: eight stripes over a width of 12 (uneven stripe widths)
    s.mode = 4; s.pv = 1'b1; s.W = 12;
    program_cfg(s);
    push_frame(s, "R6 bars");
    start(s);
    drain();
    settle();

    // R7: inverted polarity, idle level first
    s.mode = 1; s.W = 16; s.pol = 2'b11;
    program_cfg(s);
    repeat (3) @(negedge clk);
    chk("R7 idle hsync", 64'(hsync), 64'd1);
    chk("R7 idle vsync", 64'(vsync), 64'd1);
    push_frame(s, "R7 inverted syncs");
    start(s);
    drain();
    settle();

    // R8 R9: mid-frame writes wait for the frame boundary
    s.pol = 2'b00;
    program_cfg(s);
    s2 = s; s2.hf = 4; s2.hs = 2; s2.hb = 2;
    push_frame(s, "R8 old line kept");
    push_frame(s2, "R8 new line applied");
    for (int i = 0; i < 30; i++) q.push_back(off_item(2'b00, "R9 off after frame"));
    start(s);
    repeat (40) @(posedge clk);
    write_reg(1, {10'(s2.hb), 11'(s2.hs), 11'(s2.hf)});
    repeat (200) @(posedge clk);
    write_reg(0, 32'd0);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule